// File: doc/BRIEF.md
# Grouped Interrupt Request Register Bank

This block holds the pending-interrupt state for eighteen interrupt groups, numbered 2 through 19. Each group serves four sources. A one-cycle pulse from a source latches a sticky request flag. Each group also carries four enable bits and a three-bit priority level. A source counts as detected when both its request and its enable are set. A group is pending when any of its four sources is detected.

Software reaches every group through one 16-bit word on a plain register port. The word address is the group number minus two. Writes take a single-cycle strobe, and reads return data combinationally. Software cannot write a request flag directly. In each write, the low nibble acts as a per-source qualifier: only a source whose qualifier bit is 1 takes the request value written for it.

A combinational resolver looks at all pending groups and names the most urgent one, along with its level. A lower level value is more urgent. Level 7 parks a group so that it never wins. There is no data stream in this block, so every pin is a plain control or status signal with no handshake.

Top module: `irq_group_bank`

## Requirements
- R1: Each group word reads as follows. Bit 15 always reads 0. Bits 14:12 hold the level, bits 11:8 hold the enables (bit 8+s for source s), bits 7:4 hold the requests (bit 4+s), and bits 3:0 hold the detections (bit s). A read at address group−2 returns the word in the same cycle.
- R2: After reset every register field is 0, every grp_pending bit is 0, and win_valid is 0.
- R3: A 1 on src_pulse[(g−2)*4+s] sets request bit s of group g at the next rising clock edge. The bit then stays set until software clears it.
- R4: When a write hits group g, request bit s takes wdata[4+s] only if wdata[s] is 1. If wdata[s] is 0, request bit s keeps its value. Without a pulse or a qualified write, a request never changes.
- R5: A source pulse and a qualified clear of the same request bit in the same cycle leave that bit at 1.
- R6: Detection bit s always reads as enable s AND request s. Write data in bits 3:0 is never stored.
- R7: A write stores wdata[14:12] as the level and wdata[11:8] as the enables. A 1 written to bit 15 has no effect.
- R8: grp_pending[g−2] is the OR of group g's detection bits. grp_level[(g−2)*3 +: 3] is group g's level. Both follow the register state without delay.
- R9: Among pending groups whose level is not 7, the resolver picks the lowest level. When levels tie, it picks the lowest group number. win_group carries the group number (2..19) and win_level carries its level.
- R10: A group at level 7 never wins. win_valid is 0 when no pending group has a level below 7.
- R11: A write to an address of 18 or more changes nothing, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | 72 | Source pulses, bit (g−2)*4+s for source s of group g |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 5 | Word address, group number minus 2 |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data of the addressed word |
| grp_pending | output | 18 | Per-group pending flags |
| grp_level | output | 54 | Per-group levels, 3 bits per group |
| win_valid | output | 1 | A pending group with level below 7 exists |
| win_group | output | 5 | Winning group number |
| win_level | output | 3 | Level of the winning group |

## Verification
A source pulse or a write changes the stored fields at the first rising edge that samples it, so those results are due one cycle after the stimulus.

The following outputs are pure logic on the stored state and the current address, so they settle in the same cycle as that state:
- rdata
- the detection bits
- grp_pending and grp_level
- the resolver outputs

The bench drives inputs on the falling edge and updates its reference model at the following rising edge. It then compares rdata, the pending flags and the winner at the next falling edge, which is exactly one register stage after the stimulus. Address-only reads are checked a short delay after the address changes, with no clock edge in between.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;
  localparam int SRCS     = 4;
  localparam int LVL_W    = 3;
  localparam int WORD_W   = 16;
  localparam int DET_LSB  = 0;
  localparam int REQ_LSB  = DET_LSB + SRCS;
  localparam int EN_LSB   = REQ_LSB + SRCS;
  localparam int LVL_LSB  = EN_LSB + SRCS;
  localparam logic [LVL_W-1:0] LVL_PARKED = '1;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [SRCS-1:0]  en;
    logic [SRCS-1:0]  req;
  } grp_state_t;
endpackage

// File: rtl/irq_group_reg.sv
module irq_group_reg
  import irq_group_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [WORD_W-2:0] wdata,
  input  logic [SRCS-1:0]   pulse,
  output grp_state_t        state,
  output logic [WORD_W-1:0] rd_word,
  output logic              pending
);
  grp_state_t       st_q;
  logic [SRCS-1:0]  qual;
  logic [SRCS-1:0]  req_wr;
  logic [SRCS-1:0]  req_nx;
  logic [SRCS-1:0]  det;

  always_comb begin
    qual   = sel ? wdata[DET_LSB +: SRCS] : '0;
    req_wr = (st_q.req & ~qual) | (wdata[REQ_LSB +: SRCS] & qual);
    req_nx = req_wr | pulse;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q.req <= req_nx;
      if (sel) begin
        st_q.lvl <= wdata[LVL_LSB +: LVL_W];
        st_q.en  <= wdata[EN_LSB +: SRCS];
      end
    end
  end

  assign det     = st_q.en & st_q.req;
  assign pending = |det;
  assign state   = st_q;
  assign rd_word = {1'b0, st_q.lvl, st_q.en, st_q.req, det};
endmodule

// File: rtl/irq_group_resolve.sv
module irq_group_resolve
  import irq_group_pkg::*;
#(
  parameter int NUM_GROUPS  = 18,
  parameter int FIRST_GROUP = 2,
  parameter int GNUM_W      = 5
)(
  input  logic [NUM_GROUPS-1:0]       pend,
  input  logic [NUM_GROUPS*LVL_W-1:0] lvl_flat,
  output logic                        win_valid,
  output logic [GNUM_W-1:0]           win_group,
  output logic [LVL_W-1:0]            win_level
);
  logic             found;
  logic [LVL_W-1:0] best_l;
  logic [GNUM_W-1:0] best_g;
  logic [LVL_W-1:0] lv;

  always_comb begin
    found  = 1'b0;
    best_l = LVL_PARKED;
    best_g = '0;
    lv     = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      lv = lvl_flat[g*LVL_W +: LVL_W];
      if (pend[g] && (lv != LVL_PARKED) && (!found || (lv < best_l))) begin
        found  = 1'b1;
        best_l = lv;
        best_g = GNUM_W'(g + FIRST_GROUP);
      end
    end
  end

  assign win_valid = found;
  assign win_group = best_g;
  assign win_level = best_l;
endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank
  import irq_group_pkg::*;
#(
  parameter int NUM_GROUPS  = 18,
  parameter int FIRST_GROUP = 2,
  localparam int ADDR_W     = $clog2(NUM_GROUPS),
  localparam int GNUM_W     = $clog2(FIRST_GROUP + NUM_GROUPS),
  localparam int NSRC       = NUM_GROUPS * SRCS
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             src_pulse,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [WORD_W-1:0]           wdata,
  output logic [WORD_W-1:0]           rdata,
  output logic [NUM_GROUPS-1:0]       grp_pending,
  output logic [NUM_GROUPS*LVL_W-1:0] grp_level,
  output logic                        win_valid,
  output logic [GNUM_W-1:0]           win_group,
  output logic [LVL_W-1:0]            win_level
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_GROUPS - 1);

  logic [WORD_W-1:0] words [NUM_GROUPS];
  grp_state_t        st    [NUM_GROUPS];
  logic [NSRC-1:0]   req_all;
  logic [NSRC-1:0]   en_all;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic sel;
    assign sel = wr_en && (addr == ADDR_W'(g));
    irq_group_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .wdata   (wdata[WORD_W-2:0]),
      .pulse   (src_pulse[g*SRCS +: SRCS]),
      .state   (st[g]),
      .rd_word (words[g]),
      .pending (grp_pending[g])
    );
    assign grp_level[g*LVL_W +: LVL_W] = st[g].lvl;
    assign req_all[g*SRCS +: SRCS]     = st[g].req;
    assign en_all[g*SRCS +: SRCS]      = st[g].en;
  end

  always_comb begin
    rdata = '0;
    if (addr <= LAST_ADDR) rdata = words[addr];
  end

  irq_group_resolve #(
    .NUM_GROUPS  (NUM_GROUPS),
    .FIRST_GROUP (FIRST_GROUP),
    .GNUM_W      (GNUM_W)
  ) u_resolve (
    .pend      (grp_pending),
    .lvl_flat  (grp_level),
    .win_valid (win_valid),
    .win_group (win_group),
    .win_level (win_level)
  );
endmodule

// File: rtl/irq_group_bank_chk.sv
module irq_group_bank_chk
  import irq_group_pkg::*;
#(
  parameter int NUM_GROUPS  = 18,
  parameter int FIRST_GROUP = 2,
  localparam int ADDR_W     = $clog2(NUM_GROUPS),
  localparam int GNUM_W     = $clog2(FIRST_GROUP + NUM_GROUPS),
  localparam int NSRC       = NUM_GROUPS * SRCS
)(
  input logic                        clk,
  input logic                        rst_n,
  input logic [NSRC-1:0]             src_pulse,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [WORD_W-1:0]           wdata,
  input logic [WORD_W-1:0]           rdata,
  input logic [NUM_GROUPS-1:0]       grp_pending,
  input logic [NUM_GROUPS*LVL_W-1:0] grp_level,
  input logic                        win_valid,
  input logic [GNUM_W-1:0]           win_group,
  input logic [LVL_W-1:0]            win_level,
  input logic [NSRC-1:0]             req_all,
  input logic [NSRC-1:0]             en_all
);
  int widx;
  assign widx = int'(win_group) - FIRST_GROUP;

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[WORD_W-1]) |=> (rdata[WORD_W-1] == 1'b0));

  // R9
  win_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (grp_pending[widx] && (grp_level[widx*LVL_W +: LVL_W] == win_level)));

  // R10
  win_not_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_level != LVL_PARKED));

  // R11
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) >= NUM_GROUPS) |-> (rdata == '0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    // R7
    lvl_en_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == ADDR_W'(g))) |=>
        ((grp_level[g*LVL_W +: LVL_W] == $past(wdata[LVL_LSB +: LVL_W])) &&
         (en_all[g*SRCS +: SRCS] == $past(wdata[EN_LSB +: SRCS]))));
    for (genvar s = 0; s < SRCS; s++) begin : g_src
      // R3
      pulse_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_pulse[g*SRCS+s] |=> req_all[g*SRCS+s]);
      // R4
      req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_pulse[g*SRCS+s] && !(wr_en && (addr == ADDR_W'(g)) && wdata[DET_LSB+s]))
          |=> (req_all[g*SRCS+s] == $past(req_all[g*SRCS+s])));
      // R4
      req_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_pulse[g*SRCS+s] && wr_en && (addr == ADDR_W'(g)) && wdata[DET_LSB+s])
          |=> (req_all[g*SRCS+s] == $past(wdata[REQ_LSB+s])));
    end
  end
endmodule

bind irq_group_bank irq_group_bank_chk #(
  .NUM_GROUPS  (NUM_GROUPS),
  .FIRST_GROUP (FIRST_GROUP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_pulse   (src_pulse),
  .wr_en       (wr_en),
  .addr        (addr),
  .wdata       (wdata),
  .rdata       (rdata),
  .grp_pending (grp_pending),
  .grp_level   (grp_level),
  .win_valid   (win_valid),
  .win_group   (win_group),
  .win_level   (win_level),
  .req_all     (req_all),
  .en_all      (en_all)
);

// File: tb/irq_group_bank_tb.sv
`timescale 1ns/1ps
module irq_group_bank_tb;
  localparam int NG = 18;
  localparam int NB = NG * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] src_pulse = '0;
  logic          wr_en = 1'b0;
  logic [4:0]    addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [NG-1:0] grp_pending;
  logic [NG*3-1:0] grp_level;
  logic          win_valid;
  logic [4:0]    win_group;
  logic [2:0]    win_level;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [2:0] m_lvl [NG];
  logic [3:0] m_en  [NG];
  logic [3:0] m_req [NG];

  always #2.5 clk = ~clk;

  irq_group_bank u_dut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .grp_pending(grp_pending),
    .grp_level(grp_level), .win_valid(win_valid), .win_group(win_group),
    .win_level(win_level)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [4:0] a);
    logic [15:0] w;
    w = '0;
    if (int'(a) < NG) begin
      w[14:12] = m_lvl[a];
      w[11:8]  = m_en[a];
      w[7:4]   = m_req[a];
      for (int s = 0; s < 4; s++) w[s] = m_en[a][s] & m_req[a][s];
    end
    return w;
  endfunction

  task automatic m_winner(output bit v, output logic [4:0] grp, output logic [2:0] lvl);
    int best;
    best = 7;
    v = 1'b0; grp = '0; lvl = '0;
    for (int g = 0; g < NG; g++)
      if (((m_en[g] & m_req[g]) != 0) && (int'(m_lvl[g]) < best)) best = int'(m_lvl[g]);
    if (best < 7) begin
      for (int g = NG - 1; g >= 0; g--)
        if (((m_en[g] & m_req[g]) != 0) && (int'(m_lvl[g]) == best)) grp = 5'(g + 2);
      v = 1'b1;
      lvl = 3'(best);
    end
  endtask

  task automatic compare_all();
    bit v; logic [4:0] g; logic [2:0] l;
    logic [NG-1:0] ep;
    logic [NG*3-1:0] el;
    for (int i = 0; i < NG; i++) begin
      ep[i] = (m_en[i] & m_req[i]) != 0;
      el[i*3 +: 3] = m_lvl[i];
    end
    m_winner(v, g, l);
    chk(rdata == m_read(addr), "R6 rdata word", 32'(rdata), 32'(m_read(addr)));
    chk((grp_pending == ep) && (grp_level == el), "R8 pending/level", 32'(grp_pending), 32'(ep));
    chk((win_valid == v) && (!v || ((win_group == g) && (win_level == l))), "R9 winner",
        {win_valid, 23'd0, win_group, win_level}, {v, 23'd0, g, l});
  endtask

  task automatic tick(input logic [NB-1:0] p, input logic we, input logic [4:0] a, input logic [15:0] wd);
    src_pulse = p; wr_en = we; addr = a; wdata = wd;
    @(posedge clk);
    for (int g = 0; g < NG; g++) begin
      if (we && (int'(a) == g)) begin
        m_lvl[g] = wd[14:12];
        m_en[g]  = wd[11:8];
        for (int s = 0; s < 4; s++) if (wd[s]) m_req[g][s] = wd[4+s];
      end
      for (int s = 0; s < 4; s++) if (p[g*4+s]) m_req[g][s] = 1'b1;
    end
    @(negedge clk);
    src_pulse = '0; wr_en = 1'b0;
    compare_all();
  endtask

  task automatic peek(input logic [4:0] a);
    addr = a;
    #1;
  endtask

  function automatic logic [NB-1:0] pbit(input int g, input int s);
    logic [NB-1:0] v;
    v = '0;
    v[(g-2)*4+s] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) begin m_lvl[g] = '0; m_en[g] = '0; m_req[g] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R2: everything clear after reset
    for (int a = 0; a < NG; a++) begin
      peek(5'(a));
      chk(rdata == 16'h0, "R2 reset word", 32'(rdata), 32'h0);
    end
    chk((grp_pending == '0) && !win_valid, "R2 reset pending", 32'(grp_pending), 32'h0);

    // R7 R1: group 5 level 4, all enables, bit 15 written 1
    tick('0, 1'b1, 5'd3, 16'hCF00);
    chk(rdata == 16'h4F00, "R7 level/enable store", 32'(rdata), 32'h4F00);
    chk(rdata[15] == 1'b0, "R1 reserved bit reads 0", 32'(rdata[15]), 32'h0);

    // R3: pulse group 5 source 2
    tick(pbit(5, 2), 1'b0, 5'd3, 16'h0);
    chk(rdata == 16'h4F44, "R3 pulse sets request", 32'(rdata), 32'h4F44);
    chk(win_valid && (win_group == 5'd5) && (win_level == 3'd4), "R9 single winner", 32'(win_group), 32'd5);

    // R6: request without enable gives no detection
    tick(pbit(3, 0), 1'b0, 5'd1, 16'h0);
    chk(rdata == 16'h0010, "R6 detect needs enable", 32'(rdata), 32'h0010);

    // R4: unqualified write keeps request, qualified clears
    tick('0, 1'b1, 5'd3, 16'h4F00);
    chk(rdata == 16'h4F44, "R4 unqualified keeps", 32'(rdata), 32'h4F44);
    tick('0, 1'b1, 5'd3, 16'h4F04);
    chk(rdata == 16'h4F00, "R4 qualified clear", 32'(rdata), 32'h4F00);

    // R5: pulse beats same-cycle clear
    tick(pbit(5, 1), 1'b1, 5'd3, 16'h4F02);
    chk(rdata == 16'h4F22, "R5 pulse wins over clear", 32'(rdata), 32'h4F22);

    // R6 R4: qualified set, then enable change recomputes detection
    tick('0, 1'b1, 5'd3, 16'h4FFF);
    chk(rdata == 16'h4FFF, "R4 qualified set", 32'(rdata), 32'h4FFF);
    tick('0, 1'b1, 5'd3, 16'h4300);
    chk(rdata == 16'h43F3, "R6 detection recomputed", 32'(rdata), 32'h43F3);

    // R9: tie at level 4 -> lower group 3
    tick('0, 1'b1, 5'd1, 16'h4100);
    chk(win_valid && (win_group == 5'd3), "R9 tie lowest group", 32'(win_group), 32'd3);
    tick('0, 1'b1, 5'd8, 16'h2F00);
    tick(pbit(10, 3), 1'b0, 5'd8, 16'h0);
    chk(win_valid && (win_group == 5'd10) && (win_level == 3'd2), "R9 lower level wins", 32'(win_group), 32'd10);

    // R10: parked groups
    tick('0, 1'b1, 5'd8, 16'h7F00);
    chk(grp_pending[8] && (win_group == 5'd3), "R10 parked group skipped", 32'(win_group), 32'd3);
    tick('0, 1'b1, 5'd1, 16'h7100);
    tick('0, 1'b1, 5'd3, 16'h7300);
    chk(!win_valid, "R10 all parked no winner", 32'(win_valid), 32'h0);

    // R11: out-of-range write and read
    tick('0, 1'b1, 5'd20, 16'h1FFF);
    peek(5'd20);
    chk(rdata == 16'h0, "R11 read beyond range", 32'(rdata), 32'h0);
    for (int a = 0; a < NG; a++) begin
      peek(5'(a));
      chk(rdata == m_read(5'(a)), "R11 write beyond range ignored", 32'(rdata), 32'(m_read(5'(a))));
    end

    // Mixed traffic, compared every clock
    for (int n = 0; n < 600; n++) begin
      logic [NB-1:0] p;
      logic we;
      p = '0;
      for (int b = 0; b < NB; b++) p[b] = ($urandom_range(0, 15) == 0);
      we = ($urandom_range(0, 2) == 0);
      tick(p, we, 5'($urandom_range(0, 19)), 16'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule